// File: doc/BRIEF.md
# Blender Pipe Un-premultiply Stage

This block is the front end of a four-pipe colour blender. Every pipe takes its pixel from one of four overlay sources. A packed route word chooses the source for each pipe. A four-bit flag word marks the pipes whose pixels carry premultiplied colour. For a marked pipe, each colour channel is returned to straight form: it is divided by the normalised alpha, rounded to the nearest integer and saturated at full scale. Alpha is never changed. The Porter-Duff mixing that follows is done elsewhere.

The route and flag words are sampled only on a frame-start strobe, so every pixel of a frame sees one setting. The data path is a fully pipelined restoring divider. It accepts one pixel on every cycle and has a fixed latency.

Top module: `pipe_unpremul_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `pipe_px` is all zero. The active route is the identity (pipe n takes source n) and no pipe is flagged.
- R2: A pixel presented with `px_valid` high in cycle t appears with `out_valid` high in cycle t+10 (CW+2). Pixels may arrive back to back, the order is kept, and there is one result for each accepted pixel.
- R3: The active route holds the source field of pipe n at bits [4n+3:4n]. Field values 0 to 3 select `src_px` source 0 to 3. Any value of 4 or more feeds the pipe an all-zero pixel.
- R4: A pixel word places alpha at bits [31:24] and colours at [23:16], [15:8] and [7:0]. The output alpha always equals the input alpha.
- R5: An unflagged pipe passes its colour channels through unchanged.
- R6: On a flagged pipe with alpha a > 0, each colour c becomes min(255, floor((c*255 + floor(a/2)) / a)).
- R7: On a flagged pipe with alpha 0, every colour output is 0.
- R8: Bit n of the active flag word controls pipe n alone. The pipes can be flagged in any mix.
- R9: The active route and flag words load from `route_cfg` and `premul_cfg` only in a cycle with `frame_start` high. The pixel presented in that cycle already uses the new words. Changes to the configuration inputs in other cycles have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Loads the configuration words |
| route_cfg | input | 16 | Pending source select, 4 bits per pipe |
| premul_cfg | input | 4 | Pending premultiplied flags, one per pipe |
| px_valid | input | 1 | Source pixels valid this cycle |
| src_px | input | 128 | Four source pixels, source s at bits [32s+31:32s] |
| out_valid | output | 1 | Output pixels valid |
| pipe_px | output | 128 | Four pipe pixels, pipe n at bits [32n+31:32n] |

## Verification
The hardest case to reach is the divider's edge: results that land exactly at full scale, or that would land just above it. They decide whether a pixel takes the saturating path or the divide path, and they occur only for certain colour and alpha pairs. The stimulus therefore sweeps every colour against every alpha on all four pipes, with each pipe fed by a differently skewed source, and so reaches every boundary pair.

A second hard case is a configuration change that lands in the same cycle as a pixel. Streams rewrite the configuration inputs in the middle of a frame and pulse the strobe alongside live pixels. Each result must then follow the words latched at the last strobe.

// File: rtl/unpm_pkg.sv
package unpm_pkg;

  typedef enum logic [1:0] {
    CM_PASS = 2'd0,
    CM_ZERO = 2'd1,
    CM_SAT  = 2'd2,
    CM_DIV  = 2'd3
  } col_mode_e;

  function automatic col_mode_e classify(input logic flagged, input logic a_zero,
                                         input logic over);
    if (!flagged)    return CM_PASS;
    else if (a_zero) return CM_ZERO;
    else if (over)   return CM_SAT;
    else             return CM_DIV;
  endfunction

endpackage

// File: rtl/unpm_div_step.sv
module unpm_div_step #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] rem_i,
  input  logic          bit_i,
  input  logic [CW-1:0] den_i,
  output logic [CW-1:0] rem_o,
  output logic          qbit_o
);
  logic [CW:0] trial;
  logic [CW:0] diff;

  always_comb begin
    trial  = {rem_i, bit_i};
    diff   = trial - {1'b0, den_i};
    qbit_o = (trial >= {1'b0, den_i});
    rem_o  = qbit_o ? diff[CW-1:0] : trial[CW-1:0];
  end
endmodule

// File: rtl/unpm_route.sv
module unpm_route #(
  parameter int NPIPE = 4,
  parameter int NSRC  = 4,
  parameter int SELW  = 4,
  parameter int PXW   = 32
) (
  input  logic [NPIPE*SELW-1:0] route_i,
  input  logic [NSRC*PXW-1:0]   src_px_i,
  output logic [NPIPE*PXW-1:0]  pipe_px_o
);
  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic [SELW-1:0] sel;
    assign sel = route_i[p*SELW +: SELW];
    always_comb begin
      pipe_px_o[p*PXW +: PXW] = '0;
      for (int s = 0; s < NSRC; s++) begin
        if (int'(sel) == s) pipe_px_o[p*PXW +: PXW] = src_px_i[s*PXW +: PXW];
      end
    end
  end
endmodule

// File: rtl/unpm_pipe.sv
module unpm_pipe
  import unpm_pkg::*;
#(
  parameter int CW   = 8,
  parameter int NCOL = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vld_i,
  input  logic                  premul_i,
  input  logic [(NCOL+1)*CW-1:0] px_i,
  output logic                  vld_o,
  output logic [(NCOL+1)*CW-1:0] px_o
);
  localparam int PXW = (NCOL+1)*CW;
  localparam int DW  = 2*CW;
  localparam logic [CW-1:0] MAXV = '1;

  // stage s holds the operands before divider step s; stage CW is the last
  logic [CW-1:0] rem_q  [CW][NCOL];
  logic [CW-1:0] lo_q   [CW][NCOL];
  logic [CW-1:0] quo_q  [CW+1][NCOL];
  logic [CW-1:0] byp_q  [CW+1][NCOL];
  logic          div_q  [CW+1][NCOL];
  logic [CW-1:0] alpha_q[CW+1];
  logic          vld_q  [CW+1];

  logic [CW-1:0] rem_n  [CW][NCOL];
  logic          qb_n   [CW][NCOL];

  // entry classification
  logic [CW-1:0] in_alpha;
  logic [DW-1:0] dvd   [NCOL];
  logic          over  [NCOL];
  col_mode_e     mode  [NCOL];
  logic [CW-1:0] byp_d [NCOL];

  assign in_alpha = px_i[NCOL*CW +: CW];

  always_comb begin
    for (int k = 0; k < NCOL; k++) begin
      dvd[k]  = DW'(px_i[k*CW +: CW]) * DW'(MAXV) + DW'(in_alpha >> 1);
      over[k] = {1'b0, dvd[k]} >= ((DW+1)'(in_alpha) << CW);
      mode[k] = classify(premul_i, in_alpha == '0, over[k]);
      unique case (mode[k])
        CM_PASS: byp_d[k] = px_i[k*CW +: CW];
        CM_SAT:  byp_d[k] = MAXV;
        default: byp_d[k] = '0;
      endcase
    end
  end

  for (genvar s = 0; s < CW; s++) begin : g_stage
    for (genvar k = 0; k < NCOL; k++) begin : g_col
      unpm_div_step #(.CW(CW)) u_step (
        .rem_i  (rem_q[s][k]),
        .bit_i  (lo_q[s][k][CW-1]),
        .den_i  (alpha_q[s]),
        .rem_o  (rem_n[s][k]),
        .qbit_o (qb_n[s][k])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s <= CW; s++) begin
        vld_q[s]   <= 1'b0;
        alpha_q[s] <= '0;
        for (int k = 0; k < NCOL; k++) begin
          quo_q[s][k] <= '0;
          byp_q[s][k] <= '0;
          div_q[s][k] <= 1'b0;
          if (s < CW) begin
            rem_q[s][k] <= '0;
            lo_q[s][k]  <= '0;
          end
        end
      end
      vld_o <= 1'b0;
      px_o  <= '0;
    end else begin
      vld_q[0]   <= vld_i;
      alpha_q[0] <= in_alpha;
      for (int k = 0; k < NCOL; k++) begin
        rem_q[0][k] <= dvd[k][DW-1:CW];
        lo_q[0][k]  <= dvd[k][CW-1:0];
        quo_q[0][k] <= '0;
        byp_q[0][k] <= byp_d[k];
        div_q[0][k] <= (mode[k] == CM_DIV);
      end
      for (int s = 0; s < CW; s++) begin
        vld_q[s+1]   <= vld_q[s];
        alpha_q[s+1] <= alpha_q[s];
        for (int k = 0; k < NCOL; k++) begin
          quo_q[s+1][k] <= {quo_q[s][k][CW-2:0], qb_n[s][k]};
          byp_q[s+1][k] <= byp_q[s][k];
          div_q[s+1][k] <= div_q[s][k];
          if (s + 1 < CW) begin
            rem_q[s+1][k] <= rem_n[s][k];
            lo_q[s+1][k]  <= {lo_q[s][k][CW-2:0], 1'b0};
          end
        end
      end
      vld_o <= vld_q[CW];
      px_o[NCOL*CW +: CW] <= alpha_q[CW];
      for (int k = 0; k < NCOL; k++) begin
        px_o[k*CW +: CW] <= div_q[CW][k] ? quo_q[CW][k] : byp_q[CW][k];
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^{PXW};
endmodule

// File: rtl/pipe_unpremul_stage.sv
module pipe_unpremul_stage #(
  parameter int NPIPE = 4,
  parameter int NSRC  = 4,
  parameter int CW    = 8,
  parameter int NCOL  = 3,
  parameter int SELW  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          frame_start,
  input  logic [NPIPE*SELW-1:0]         route_cfg,
  input  logic [NPIPE-1:0]              premul_cfg,
  input  logic                          px_valid,
  input  logic [NSRC*(NCOL+1)*CW-1:0]   src_px,
  output logic                          out_valid,
  output logic [NPIPE*(NCOL+1)*CW-1:0]  pipe_px
);
  localparam int PXW = (NCOL+1)*CW;
  localparam int RTW = NPIPE*SELW;

  function automatic logic [RTW-1:0] identity_route();
    logic [RTW-1:0] r;
    r = '0;
    for (int n = 0; n < NPIPE; n++) r[n*SELW +: SELW] = SELW'(n);
    return r;
  endfunction

  localparam logic [RTW-1:0] ROUTE_ID = identity_route();

  logic [RTW-1:0]       route_act;
  logic [NPIPE-1:0]     prem_act;
  logic [RTW-1:0]       route_eff;
  logic [NPIPE-1:0]     prem_eff;
  logic [NPIPE*PXW-1:0] routed;
  logic [NPIPE-1:0]     pipe_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      route_act <= ROUTE_ID;
      prem_act  <= '0;
    end else if (frame_start) begin
      route_act <= route_cfg;
      prem_act  <= premul_cfg;
    end
  end

  // the pixel sharing the strobe cycle already follows the new frame
  assign route_eff = frame_start ? route_cfg  : route_act;
  assign prem_eff  = frame_start ? premul_cfg : prem_act;

  unpm_route #(
    .NPIPE (NPIPE),
    .NSRC  (NSRC),
    .SELW  (SELW),
    .PXW   (PXW)
  ) u_route (
    .route_i   (route_eff),
    .src_px_i  (src_px),
    .pipe_px_o (routed)
  );

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    unpm_pipe #(.CW(CW), .NCOL(NCOL)) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .vld_i    (px_valid),
      .premul_i (prem_eff[p]),
      .px_i     (routed[p*PXW +: PXW]),
      .vld_o    (pipe_vld[p]),
      .px_o     (pipe_px[p*PXW +: PXW])
    );
  end

  assign out_valid = &pipe_vld;
endmodule

// File: rtl/pipe_unpremul_stage_chk.sv
module pipe_unpremul_stage_chk #(
  parameter int NPIPE = 4,
  parameter int SELW  = 4,
  parameter int CW    = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  frame_start,
  input logic                  px_valid,
  input logic                  out_valid,
  input logic [NPIPE*SELW-1:0] route_cfg,
  input logic [NPIPE-1:0]      premul_cfg,
  input logic [NPIPE*SELW-1:0] route_act,
  input logic [NPIPE-1:0]      prem_act
);
  localparam int LAT = CW + 2;

  logic [LAT-1:0] vhist;
  always_ff @(posedge clk) begin
    if (rst) vhist <= '0;
    else     vhist <= {vhist[LAT-2:0], px_valid};
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);                                            // R1
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    out_valid == vhist[LAT-1]);                                            // R2
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(route_act));                                  // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(prem_act));                                   // R9
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (route_act == $past(route_cfg)) && (prem_act == $past(premul_cfg))); // R9
endmodule

bind pipe_unpremul_stage pipe_unpremul_stage_chk #(
  .NPIPE (NPIPE),
  .SELW  (SELW),
  .CW    (CW)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .px_valid    (px_valid),
  .out_valid   (out_valid),
  .route_cfg   (route_cfg),
  .premul_cfg  (premul_cfg),
  .route_act   (route_act),
  .prem_act    (prem_act)
);

// File: tb/pipe_unpremul_stage_tb.sv
module pipe_unpremul_stage_tb_top;
  localparam int NP  = 4;
  localparam int PXW = 32;
  localparam int LAT = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            frame_start = 1'b0;
  logic [15:0]     route_cfg = '0;
  logic [3:0]      premul_cfg = '0;
  logic            px_valid = 1'b0;
  logic [127:0]    src_px = '0;
  logic            out_valid;
  logic [127:0]    pipe_px;

  pipe_unpremul_stage dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .route_cfg(route_cfg),
    .premul_cfg(premul_cfg), .px_valid(px_valid), .src_px(src_px),
    .out_valid(out_valid), .pipe_px(pipe_px)
  );

  always #2ns clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int tag_ovr = 0;

  logic [15:0] m_route = 16'h3210;   // R1 identity after reset
  logic [3:0]  m_flag  = 4'h0;

  logic [127:0] exp_q[$];
  logic [15:0]  tag_q[$];
  int           cyc_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_col(int c, int a, bit f);
    int v;
    if (!f) return c;             // R5
    if (a == 0) return 0;         // R7
    v = (c * 255 + a / 2) / a;    // R6
    return (v > 255) ? 255 : v;
  endfunction

  task automatic report(string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(logic [127:0] srcv, bit fs, bit vld);
    logic [127:0] e;
    logic [15:0]  tags;
    @(negedge clk);
    src_px = srcv; frame_start = fs; px_valid = vld;
    if (fs) begin m_route = route_cfg; m_flag = premul_cfg; end   // R9
    if (vld) begin
      for (int p = 0; p < NP; p++) begin
        int sel;
        logic [31:0] px;
        int t;
        sel = int'(m_route[4*p +: 4]);
        px = (sel < 4) ? srcv[32*sel +: 32] : 32'h0;   // R3
        e[32*p+24 +: 8] = px[31:24];                   // R4
        for (int k = 0; k < 3; k++)
          e[32*p+8*k +: 8] = 8'(ref_col(int'(px[8*k +: 8]), int'(px[31:24]), m_flag[p]));
        if (sel >= 4) t = 3;
        else if (!m_flag[p]) t = 5;
        else if (px[31:24] == 0) t = 7;
        else t = 6;
        if (tag_ovr != 0 && t != 3) t = tag_ovr;
        tags[4*p +: 4] = 4'(t);
      end
      exp_q.push_back(e); tag_q.push_back(tags); cyc_q.push_back(cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=unexpected out_valid expected=no output");
      end else begin
        logic [127:0] e;
        logic [15:0]  tg;
        int c0;
        e = exp_q.pop_front(); tg = tag_q.pop_front(); c0 = cyc_q.pop_front();
        checks++;
        if (cyc != c0 + LAT) begin   // R2 latency
          errors++;
          $display("FAIL R2 actual=%0d expected=%0d", cyc - c0, LAT);
        end
        for (int p = 0; p < NP; p++) begin
          if (pipe_px[32*p+24 +: 8] !== e[32*p+24 +: 8])
            report("R4", {96'h0, pipe_px[32*p +: 32]}, {96'h0, e[32*p +: 32]});
          else
            report($sformatf("R%0d", tg[4*p +: 4]), {96'h0, pipe_px[32*p +: 32]}, {96'h0, e[32*p +: 32]});
        end
      end
    end
  end

  function automatic logic [127:0] pattern(int a, int c);
    logic [127:0] v;
    for (int s = 0; s < 4; s++) begin
      v[32*s+24 +: 8] = (s == 3) ? 8'(255 - a) : 8'(a);
      v[32*s+16 +: 8] = 8'(c + 37 * s);
      v[32*s+8  +: 8] = 8'(255 - c);
      v[32*s    +: 8] = 8'(c) ^ 8'(8'h33 * s);
    end
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state at the ports
    report("R1", {127'h0, out_valid}, 128'h0);
    report("R1", pipe_px, 128'h0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    report("R1", {127'h0, out_valid}, 128'h0);

    // R1 defaults; configuration inputs move without a strobe (R9)
    route_cfg = 16'hFFFF; premul_cfg = 4'hF; tag_ovr = 1;
    for (int i = 0; i < 16; i++) send(pattern(i * 16 + 3, i * 15), 1'b0, 1'b1);
    tag_ovr = 0;

    // R6 R7 R3: full colour x alpha sweep, all pipes flagged, permuted route
    route_cfg = 16'h1302; premul_cfg = 4'hF;
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 256; c++)
        send(pattern(a, c), (a == 0 && c == 0), !(c == 100 && a[2:0] == 3'd5));

    // R8 R3: mixed flags, out-of-range selectors feed zero pixels
    route_cfg = 16'hC240; premul_cfg = 4'b0101; tag_ovr = 8;
    for (int i = 0; i < 512; i++) send(pattern(i % 256, (i * 7) % 256), (i == 0), 1'b1);

    // R9: configuration inputs churn; only strobes latch them
    tag_ovr = 9;
    for (int i = 0; i < 400; i++) begin
      if (i % 25 == 0) begin
        route_cfg = 16'(i * 16'h1357 + 16'h0213);
        premul_cfg = 4'(i / 25);
      end
      send(pattern((i * 13) % 256, (i * 29) % 256), (i % 100 == 50), (i % 9 != 4));
    end
    tag_ovr = 0;
    @(negedge clk); px_valid = 1'b0; frame_start = 1'b0;
    repeat (LAT + 6) @(negedge clk);
    // R2: every accepted pixel produced exactly one result
    report("R2", 128'(exp_q.size()), 128'h0);
    finish_run();
  end
endmodule